// File: doc/BRIEF.md
# OSD Sprite and Colour Compositor

This block produces the final colour of every dot of an on-screen display overlay. For each dot it combines, in a fixed order of precedence, one freely placed sprite, the glyph pixel of the current character cell, an outline or shadow drawn around the glyph, a per-character background and a full-screen background. The result is a 4-bit colour code with red, green, blue and intensity bits. Two keying outputs tell the video mixer where overlay content is present. A colour/monochrome select line tells downstream logic whether to read the 4 bits as 16 colours or as 16 grey levels.

The address generator upstream supplies the glyph bit of the current dot, its four neighbour bits and the attributes of the cell. The sprite glyph source supplies the sprite pixel and its edge bit for the same dot. The block compares the dot and line counters with the sprite position, which is given in 2-dot steps. It accepts the sprite only when its code is one of the eight reserved sprite codes. All outputs come from registers and follow their inputs by one clock.

Top module: `osd_compositor`

## Requirements
- R1: Inside the sprite window, with the sprite shown and `spr_bit`=1, `rgbi` is {`spr_body_color`, 1'b1}. This overrides every other layer.
- R2: The sprite is shown only when `spr_en`=1 and `spr_code` is 0x1F8 to 0x1FF inclusive. Any other code leaves the output exactly as it would be with the sprite off.
- R3: The sprite window covers dot columns 2·`spr_x` to 2·`spr_x`+23 and lines 2·`spr_y` to 2·`spr_y`+31, both ends included.
- R4: Inside the window, with `spr_bit`=0 and `spr_edge`=1, `rgbi` is {`spr_trim_color`, 1'b1}. This ranks below the sprite body and above every character layer.
- R5: With `cell_active`=1 and `glyph_c`=1, and no sprite pixel present, `rgbi` is `chr_color`.
- R6: The trim layer applies only where `cell_active`=1 and `glyph_c`=0, and it uses `trim_color`. `trim_mode` selects the shape. Code 0 or 3 draws no trim. Code 1 draws an outline, where any of `glyph_l`, `glyph_r`, `glyph_u` or `glyph_d` is 1. Code 2 draws a drop shadow, where `glyph_l` or `glyph_u` is 1. The trim ranks below the glyph.
- R7: With `cell_active`=1, the character background applies when `chr_bg_en`=1. When only `shade_en`=1, it applies on the dots where `dot_x[0]` XOR `line_y[0]` is 1. It uses `chr_bg_color` and ranks below the trim.
- R8: The screen background (`scr_bg_en`, `scr_bg_color`) is the lowest layer. `key_all` is 1 when the glyph, trim, character background or screen background layer is present. `key_chr` is 1 when the glyph, trim or character background layer is present. The sprite has no effect on either key.
- R9: `color_sel` repeats `color_mode` one clock later.
- R10: Every output follows its inputs by exactly one clock. A dot with no layer present gives `rgbi`=0 with both keys low. While `rst_n`=0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dot_x | input | X_W (11) | Dot column counter |
| line_y | input | Y_W (10) | Line counter |
| cell_active | input | 1 | Dot lies inside the character area |
| glyph_c | input | 1 | Glyph bit of the current dot |
| glyph_l | input | 1 | Glyph bit of the dot to the left |
| glyph_r | input | 1 | Glyph bit of the dot to the right |
| glyph_u | input | 1 | Glyph bit of the dot above |
| glyph_d | input | 1 | Glyph bit of the dot below |
| chr_color | input | 4 | Character colour, per cell |
| chr_bg_color | input | 4 | Character background colour, per cell |
| chr_bg_en | input | 1 | Solid character background enable, per cell |
| shade_en | input | 1 | Stippled (shaded) background enable, per cell |
| trim_mode | input | 2 | Trim shape: 0 none, 1 outline, 2 shadow, 3 none |
| trim_color | input | 4 | Trim colour, per line |
| scr_bg_en | input | 1 | Screen background enable |
| scr_bg_color | input | 4 | Screen background colour |
| color_mode | input | 1 | 1 selects colour, 0 selects grey scale |
| spr_en | input | 1 | Sprite enable |
| spr_x | input | X_W-1 (10) | Sprite column in 2-dot steps |
| spr_y | input | Y_W-1 (9) | Sprite line in 2-dot steps |
| spr_code | input | CODE_W (9) | Sprite glyph code |
| spr_bit | input | 1 | Sprite glyph pixel for this dot |
| spr_edge | input | 1 | Sprite trim pixel for this dot |
| spr_body_color | input | 3 | Sprite body colour |
| spr_trim_color | input | 3 | Sprite trim colour |
| rgbi | output | 4 | Colour code {R,G,B,I} |
| key_all | output | 1 | Key for glyph, trim, character and screen background |
| key_chr | output | 1 | Key for glyph, trim and character background only |
| color_sel | output | 1 | Colour/monochrome select |

## Verification
The bench builds the block with its default parameters: a 24×32 sprite, a 2-dot position step and shading enabled. It keeps the dot, line and sprite coordinates in small ranges, so random dots often land on all four edges of the sprite window and just outside them. Random layer enables and glyph neighbours bring every pair of adjacent priority layers into contention. Directed dots cover the first and last valid sprite codes and their neighbours, every trim code, and the two stipple phases.

// File: rtl/osd_comp_pkg.sv
package osd_comp_pkg;

   typedef enum logic [1:0] {
      TRIM_NONE    = 2'd0,
      TRIM_OUTLINE = 2'd1,
      TRIM_SHADOW  = 2'd2,
      TRIM_OFF3    = 2'd3
   } trim_mode_e;

   typedef enum logic [2:0] {
      LYR_NONE,
      LYR_SCREEN,
      LYR_CHR_BG,
      LYR_TRIM,
      LYR_GLYPH,
      LYR_SPR_TRIM,
      LYR_SPR_BODY
   } layer_e;

   localparam int unsigned RGBI_W = 4;
   localparam int unsigned SPR_C_W = 3;

   function automatic logic [RGBI_W-1:0] spr_to_rgbi(input logic [SPR_C_W-1:0] c);
      return {c, 1'b1};
   endfunction

endpackage

// File: rtl/osd_sprite_window.sv
module osd_sprite_window #(
   parameter int unsigned X_W       = 11,
   parameter int unsigned Y_W       = 10,
   parameter int unsigned STEP_LOG2 = 1,
   parameter int unsigned SPR_W     = 24,
   parameter int unsigned SPR_H     = 32,
   parameter int unsigned CODE_W    = 9,
   parameter int unsigned CODE_BASE = 9'h1F8,
   parameter int unsigned CODE_CNT  = 8
) (
   input  logic [X_W-1:0]           dot_x,
   input  logic [Y_W-1:0]           line_y,
   input  logic [X_W-STEP_LOG2-1:0] spr_x,
   input  logic [Y_W-STEP_LOG2-1:0] spr_y,
   input  logic [CODE_W-1:0]        spr_code,
   input  logic                     spr_en,
   output logic                     spr_on
);
   localparam int unsigned SX_W = X_W - STEP_LOG2;
   localparam int unsigned SY_W = Y_W - STEP_LOG2;
   localparam logic [CODE_W:0] C_LO = (CODE_W+1)'(CODE_BASE);
   localparam logic [CODE_W:0] C_HI = (CODE_W+1)'(CODE_BASE + CODE_CNT);

   logic [X_W:0] x0;
   logic [Y_W:0] y0;
   logic         code_ok;
   logic         in_x;
   logic         in_y;

   generate
      if (STEP_LOG2 == 0) begin : g_unit_step
         assign x0 = {1'b0, spr_x};
         assign y0 = {1'b0, spr_y};
      end else begin : g_coarse_step
         assign x0 = {1'b0, spr_x, {STEP_LOG2{1'b0}}};
         assign y0 = {1'b0, spr_y, {STEP_LOG2{1'b0}}};
      end
   endgenerate

   always_comb begin
      code_ok = ({1'b0, spr_code} >= C_LO) && ({1'b0, spr_code} < C_HI);
      in_x    = ({1'b0, dot_x} >= x0) && ({1'b0, dot_x} < x0 + (X_W+1)'(SPR_W));
      in_y    = ({1'b0, line_y} >= y0) && ({1'b0, line_y} < y0 + (Y_W+1)'(SPR_H));
      spr_on  = spr_en && code_ok && in_x && in_y;
   end

   logic unused_w;
   assign unused_w = ^{SX_W[0], SY_W[0]};

endmodule

// File: rtl/osd_char_layers.sv
module osd_char_layers
   import osd_comp_pkg::*;
#(
   parameter bit SHADE_EN = 1'b1
) (
   input  logic       dot_par,
   input  logic       line_par,
   input  logic       cell_active,
   input  logic       glyph_c,
   input  logic       glyph_l,
   input  logic       glyph_r,
   input  logic       glyph_u,
   input  logic       glyph_d,
   input  logic [1:0] trim_mode,
   input  logic       chr_bg_en,
   input  logic       shade_en,
   output logic       glyph_px,
   output logic       trim_px,
   output logic       cbg_px
);
   logic nb_hit;
   logic stipple;

   always_comb begin
      unique case (trim_mode_e'(trim_mode))
         TRIM_OUTLINE: nb_hit = glyph_l | glyph_r | glyph_u | glyph_d;
         TRIM_SHADOW:  nb_hit = glyph_l | glyph_u;
         default:      nb_hit = 1'b0;
      endcase
   end

   generate
      if (SHADE_EN) begin : g_shade
         assign stipple = shade_en & (dot_par ^ line_par);
      end else begin : g_no_shade
         logic unused_s;
         assign unused_s = shade_en ^ dot_par ^ line_par;
         assign stipple  = 1'b0;
      end
   endgenerate

   assign glyph_px = cell_active & glyph_c;
   assign trim_px  = cell_active & ~glyph_c & nb_hit;
   assign cbg_px   = cell_active & (chr_bg_en | stipple);

endmodule

// File: rtl/osd_layer_mux.sv
module osd_layer_mux
   import osd_comp_pkg::*;
(
   input  logic                spr_on,
   input  logic                spr_bit,
   input  logic                spr_edge,
   input  logic [SPR_C_W-1:0]  spr_body_color,
   input  logic [SPR_C_W-1:0]  spr_trim_color,
   input  logic                glyph_px,
   input  logic                trim_px,
   input  logic                cbg_px,
   input  logic                scr_px,
   input  logic [RGBI_W-1:0]   chr_color,
   input  logic [RGBI_W-1:0]   trim_color,
   input  logic [RGBI_W-1:0]   chr_bg_color,
   input  logic [RGBI_W-1:0]   scr_bg_color,
   output logic [RGBI_W-1:0]   rgbi_d,
   output logic                key_all_d,
   output logic                key_chr_d
);
   layer_e win;

   always_comb begin
      if (spr_on && spr_bit)                win = LYR_SPR_BODY;
      else if (spr_on && spr_edge)          win = LYR_SPR_TRIM;
      else if (glyph_px)                    win = LYR_GLYPH;
      else if (trim_px)                     win = LYR_TRIM;
      else if (cbg_px)                      win = LYR_CHR_BG;
      else if (scr_px)                      win = LYR_SCREEN;
      else                                  win = LYR_NONE;
   end

   always_comb begin
      unique case (win)
         LYR_SPR_BODY: rgbi_d = spr_to_rgbi(spr_body_color);
         LYR_SPR_TRIM: rgbi_d = spr_to_rgbi(spr_trim_color);
         LYR_GLYPH:    rgbi_d = chr_color;
         LYR_TRIM:     rgbi_d = trim_color;
         LYR_CHR_BG:   rgbi_d = chr_bg_color;
         LYR_SCREEN:   rgbi_d = scr_bg_color;
         default:      rgbi_d = '0;
      endcase
   end

   assign key_chr_d = glyph_px | trim_px | cbg_px;
   assign key_all_d = key_chr_d | scr_px;

endmodule

// File: rtl/osd_compositor.sv
module osd_compositor
   import osd_comp_pkg::*;
#(
   parameter int unsigned X_W       = 11,
   parameter int unsigned Y_W       = 10,
   parameter int unsigned STEP_LOG2 = 1,
   parameter int unsigned SPR_W     = 24,
   parameter int unsigned SPR_H     = 32,
   parameter int unsigned CODE_W    = 9,
   parameter int unsigned CODE_BASE = 9'h1F8,
   parameter int unsigned CODE_CNT  = 8,
   parameter bit          SHADE_EN  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [X_W-1:0]           dot_x,
   input  logic [Y_W-1:0]           line_y,
   input  logic                     cell_active,
   input  logic                     glyph_c,
   input  logic                     glyph_l,
   input  logic                     glyph_r,
   input  logic                     glyph_u,
   input  logic                     glyph_d,
   input  logic [3:0]               chr_color,
   input  logic [3:0]               chr_bg_color,
   input  logic                     chr_bg_en,
   input  logic                     shade_en,
   input  logic [1:0]               trim_mode,
   input  logic [3:0]               trim_color,
   input  logic                     scr_bg_en,
   input  logic [3:0]               scr_bg_color,
   input  logic                     color_mode,
   input  logic                     spr_en,
   input  logic [X_W-STEP_LOG2-1:0] spr_x,
   input  logic [Y_W-STEP_LOG2-1:0] spr_y,
   input  logic [CODE_W-1:0]        spr_code,
   input  logic                     spr_bit,
   input  logic                     spr_edge,
   input  logic [2:0]               spr_body_color,
   input  logic [2:0]               spr_trim_color,
   output logic [3:0]               rgbi,
   output logic                     key_all,
   output logic                     key_chr,
   output logic                     color_sel
);

   if (STEP_LOG2 >= X_W || STEP_LOG2 >= Y_W) begin : g_bad_step
      $error("osd_compositor: STEP_LOG2 must be below both counter widths");
   end
   if (SPR_W == 0 || SPR_W >= (1 << X_W) || SPR_H == 0 || SPR_H >= (1 << Y_W)) begin : g_bad_size
      $error("osd_compositor: sprite size must be nonzero and fit the counters");
   end
   if (CODE_CNT == 0 || CODE_BASE + CODE_CNT > (1 << CODE_W)) begin : g_bad_code
      $error("osd_compositor: sprite code range must fit CODE_W");
   end

   logic              spr_on;
   logic              glyph_px;
   logic              trim_px;
   logic              cbg_px;
   logic [RGBI_W-1:0] rgbi_d;
   logic              key_all_d;
   logic              key_chr_d;

   osd_sprite_window #(
      .X_W(X_W), .Y_W(Y_W), .STEP_LOG2(STEP_LOG2), .SPR_W(SPR_W), .SPR_H(SPR_H),
      .CODE_W(CODE_W), .CODE_BASE(CODE_BASE), .CODE_CNT(CODE_CNT)
   ) i_win (
      .dot_x   (dot_x),
      .line_y  (line_y),
      .spr_x   (spr_x),
      .spr_y   (spr_y),
      .spr_code(spr_code),
      .spr_en  (spr_en),
      .spr_on  (spr_on)
   );

   osd_char_layers #(.SHADE_EN(SHADE_EN)) i_chr (
      .dot_par    (dot_x[0]),
      .line_par   (line_y[0]),
      .cell_active(cell_active),
      .glyph_c    (glyph_c),
      .glyph_l    (glyph_l),
      .glyph_r    (glyph_r),
      .glyph_u    (glyph_u),
      .glyph_d    (glyph_d),
      .trim_mode  (trim_mode),
      .chr_bg_en  (chr_bg_en),
      .shade_en   (shade_en),
      .glyph_px   (glyph_px),
      .trim_px    (trim_px),
      .cbg_px     (cbg_px)
   );

   osd_layer_mux i_mux (
      .spr_on        (spr_on),
      .spr_bit       (spr_bit),
      .spr_edge      (spr_edge),
      .spr_body_color(spr_body_color),
      .spr_trim_color(spr_trim_color),
      .glyph_px      (glyph_px),
      .trim_px       (trim_px),
      .cbg_px        (cbg_px),
      .scr_px        (scr_bg_en),
      .chr_color     (chr_color),
      .trim_color    (trim_color),
      .chr_bg_color  (chr_bg_color),
      .scr_bg_color  (scr_bg_color),
      .rgbi_d        (rgbi_d),
      .key_all_d     (key_all_d),
      .key_chr_d     (key_chr_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rgbi      <= '0;
         key_all   <= 1'b0;
         key_chr   <= 1'b0;
         color_sel <= 1'b0;
      end else begin
         rgbi      <= rgbi_d;
         key_all   <= key_all_d;
         key_chr   <= key_chr_d;
         color_sel <= color_mode;
      end
   end

endmodule

// File: rtl/osd_compositor_chk.sv
module osd_compositor_chk #(
   parameter int unsigned X_W       = 11,
   parameter int unsigned Y_W       = 10,
   parameter int unsigned STEP_LOG2 = 1,
   parameter int unsigned CODE_W    = 9,
   parameter int unsigned CODE_BASE = 9'h1F8,
   parameter int unsigned CODE_CNT  = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cell_active,
   input logic                glyph_c,
   input logic                scr_bg_en,
   input logic                color_mode,
   input logic                spr_en,
   input logic [CODE_W-1:0]   spr_code,
   input logic [3:0]          rgbi,
   input logic                key_all,
   input logic                key_chr,
   input logic                color_sel
);
   logic code_bad;
   assign code_bad = ({1'b0, spr_code} < (CODE_W+1)'(CODE_BASE)) ||
                     ({1'b0, spr_code} >= (CODE_W+1)'(CODE_BASE + CODE_CNT));

   // R10: nothing enabled gives a dark, unkeyed dot one clock later
   p_blank_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!spr_en && !cell_active && !scr_bg_en) |=> (rgbi == 4'd0 && !key_all && !key_chr));

   // R2: an out-of-range sprite code shows nothing on an otherwise empty dot
   p_bad_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (code_bad && !cell_active && !scr_bg_en) |=> (rgbi == 4'd0));

   // R8: the character key is a subset of the full key
   p_key_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
      key_chr |-> key_all);

   // R8: screen background alone raises the full key
   p_scr_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scr_bg_en |=> key_all);

   // R5: a glyph dot raises the character key
   p_glyph_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_active && glyph_c) |=> key_chr);

   // R9: select line follows the mode input by one clock
   p_csel_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (color_sel == $past(color_mode)));

   // R10: outputs are zero while reset is held
   always_comb begin
      if (!rst_n) begin
         a_reset_zero_r10: assert (rgbi == 4'd0 && !key_all && !key_chr && !color_sel);
      end
   end

endmodule

bind osd_compositor osd_compositor_chk #(
   .X_W(X_W), .Y_W(Y_W), .STEP_LOG2(STEP_LOG2),
   .CODE_W(CODE_W), .CODE_BASE(CODE_BASE), .CODE_CNT(CODE_CNT)
) i_chk (.*);

// File: tb/test_osd_compositor.sv
module test_osd_compositor;
   localparam int X_W = 11;
   localparam int Y_W = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [X_W-1:0] dot_x = '0;
   logic [Y_W-1:0] line_y = '0;
   logic cell_active = 0, glyph_c = 0, glyph_l = 0, glyph_r = 0, glyph_u = 0, glyph_d = 0;
   logic [3:0] chr_color = 0, chr_bg_color = 0, trim_color = 0, scr_bg_color = 0;
   logic chr_bg_en = 0, shade_en = 0, scr_bg_en = 0, color_mode = 0, spr_en = 0;
   logic [1:0] trim_mode = 0;
   logic [X_W-2:0] spr_x = '0;
   logic [Y_W-2:0] spr_y = '0;
   logic [8:0] spr_code = '0;
   logic spr_bit = 0, spr_edge = 0;
   logic [2:0] spr_body_color = 0, spr_trim_color = 0;
   logic [3:0] rgbi;
   logic key_all, key_chr, color_sel;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   osd_compositor i_osd_compositor (
      .clk(clk), .rst_n(rst_n), .dot_x(dot_x), .line_y(line_y),
      .cell_active(cell_active), .glyph_c(glyph_c), .glyph_l(glyph_l),
      .glyph_r(glyph_r), .glyph_u(glyph_u), .glyph_d(glyph_d),
      .chr_color(chr_color), .chr_bg_color(chr_bg_color), .chr_bg_en(chr_bg_en),
      .shade_en(shade_en), .trim_mode(trim_mode), .trim_color(trim_color),
      .scr_bg_en(scr_bg_en), .scr_bg_color(scr_bg_color), .color_mode(color_mode),
      .spr_en(spr_en), .spr_x(spr_x), .spr_y(spr_y), .spr_code(spr_code),
      .spr_bit(spr_bit), .spr_edge(spr_edge), .spr_body_color(spr_body_color),
      .spr_trim_color(spr_trim_color), .rgbi(rgbi), .key_all(key_all),
      .key_chr(key_chr), .color_sel(color_sel)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      cell_active = 0; glyph_c = 0; glyph_l = 0; glyph_r = 0; glyph_u = 0; glyph_d = 0;
      chr_bg_en = 0; shade_en = 0; scr_bg_en = 0; spr_en = 0; trim_mode = 0;
      spr_bit = 0; spr_edge = 0; spr_code = 9'h1F8;
   endtask

   // Bench model of the requirements; returns expected {key_all,key_chr,rgbi}
   // and the tag of the layer that decides the colour.
   task automatic model(output logic [5:0] exp, output string tag);
      int x0, y0;
      bit sp, code_ok, gl, tr, cb, nb;
      logic [3:0] col;
      x0 = 2 * int'(spr_x);
      y0 = 2 * int'(spr_y);
      code_ok = (spr_code >= 9'h1F8);
      sp = spr_en && code_ok && int'(dot_x) >= x0 && int'(dot_x) <= x0 + 23 &&
           int'(line_y) >= y0 && int'(line_y) <= y0 + 31;
      case (trim_mode)
         2'd1: nb = glyph_l || glyph_r || glyph_u || glyph_d;
         2'd2: nb = glyph_l || glyph_u;
         default: nb = 0;
      endcase
      gl = cell_active && glyph_c;
      tr = cell_active && !glyph_c && nb;
      cb = cell_active && (chr_bg_en || (shade_en && (dot_x[0] != line_y[0])));
      if (sp && spr_bit)       begin col = {spr_body_color, 1'b1}; tag = "R1"; end
      else if (sp && spr_edge) begin col = {spr_trim_color, 1'b1}; tag = "R4"; end
      else if (gl)             begin col = chr_color;    tag = "R5"; end
      else if (tr)             begin col = trim_color;   tag = "R6"; end
      else if (cb)             begin col = chr_bg_color; tag = "R7"; end
      else if (scr_bg_en)      begin col = scr_bg_color; tag = "R8"; end
      else                     begin col = 4'd0;         tag = "R10"; end
      exp = {gl || tr || cb || scr_bg_en, gl || tr || cb, col};
   endtask

   // Inputs are set at a falling edge; the result is sampled at the next one.
   task automatic dot(input string tag_override);
      logic [5:0] e;
      string t;
      logic cm;
      model(e, t);
      cm = color_mode;
      if (tag_override != "") t = tag_override;
      @(posedge clk);
      @(negedge clk);
      check(t, int'(rgbi), int'(e[3:0]));
      check("R8", int'({key_all, key_chr}), int'(e[5:4]));
      check("R9", int'(color_sel), int'(cm));
   endtask

   initial begin
      #400000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unsigned seed;
      int unsigned r;
      seed = 32'h5EED_0A17;
      r = $urandom(seed);
      chr_color = 4'h3; chr_bg_color = 4'h5; trim_color = 4'h9; scr_bg_color = 4'hC;
      spr_body_color = 3'd6; spr_trim_color = 3'd2; color_mode = 1;
      scr_bg_en = 1; cell_active = 1; glyph_c = 1; spr_code = 9'h1F8;
      repeat (3) @(negedge clk);
      // R10: reset holds every output low
      check("R10", int'({rgbi, key_all, key_chr, color_sel}), 0);
      rst_n = 1;
      @(negedge clk);
      clear_inputs();

      // R10: empty dot
      dot("R10");
      // R3: horizontal window edges at 20 and 43, vertical at 10 and 41
      spr_en = 1; spr_x = 10; spr_y = 5; spr_bit = 1; line_y = 20;
      dot_x = 19; dot("R3");
      dot_x = 20; dot("R3");
      dot_x = 43; dot("R3");
      dot_x = 44; dot("R3");
      dot_x = 30; line_y = 9;  dot("R3");
      line_y = 10; dot("R3");
      line_y = 41; dot("R3");
      line_y = 42; dot("R3");
      // R2: code range ends, sprite over glyph
      line_y = 20; cell_active = 1; glyph_c = 1;
      spr_code = 9'h1F7; dot("R2");
      spr_code = 9'h1F8; dot("R2");
      spr_code = 9'h1FF; dot("R2");
      spr_code = 9'h0F8; dot("R2");
      spr_en = 0; spr_code = 9'h1FF; dot("R2");
      // R4: sprite trim over glyph
      spr_en = 1; spr_bit = 0; spr_edge = 1; dot("R4");
      // R6: every trim code with left neighbour, then right neighbour only
      clear_inputs(); cell_active = 1; glyph_l = 1; chr_bg_en = 1;
      for (int m = 0; m < 4; m++) begin trim_mode = 2'(m); dot("R6"); end
      glyph_l = 0; glyph_r = 1;
      trim_mode = 1; dot("R6");
      trim_mode = 2; dot("R6");
      // R7: stipple phases
      clear_inputs(); cell_active = 1; shade_en = 1; scr_bg_en = 1;
      dot_x = 4; line_y = 6; dot("R7");
      dot_x = 5; dot("R7");
      // R9: mode toggles
      color_mode = 0; dot("R9");
      color_mode = 1; dot("R9");

      // Random dots near the sprite window edges
      for (int i = 0; i < 4000; i++) begin
         r = $urandom;
         dot_x = X_W'($urandom_range(0, 90));
         line_y = Y_W'($urandom_range(0, 80));
         spr_x = 9'($urandom_range(0, 30)) + 10'd0;
         spr_y = 9'($urandom_range(0, 20));
         spr_code = r[0] ? 9'h1F8 + 9'(r[3:1]) : 9'($urandom_range(480, 511));
         spr_en = r[4]; spr_bit = r[5]; spr_edge = r[6];
         cell_active = r[7]; glyph_c = r[8]; glyph_l = r[9]; glyph_r = r[10];
         glyph_u = r[11]; glyph_d = r[12]; chr_bg_en = r[13] & r[14];
         shade_en = r[15]; scr_bg_en = r[16]; trim_mode = r[18:17];
         color_mode = r[19];
         chr_color = r[23:20]; trim_color = r[27:24]; chr_bg_color = 4'(r[31:28] ^ 4'h6);
         scr_bg_color = 4'($urandom_range(0, 15));
         spr_body_color = r[22:20]; spr_trim_color = r[26:24] ^ 3'd5;
         dot("");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule